// File: doc/BRIEF.md
# Fully Associative Tag Store with Pointer Replacement

This block is the tag side of a small fully associative cache. It has 64 entries, each holding one 32-byte block, so an address carries only a tag and a byte offset and no index. Every lookup compares its tag against all valid entries at the same time. The block reports whether the address is present and, if so, which entry holds it.

Victims are chosen with one replacement pointer instead of a full recency history. A lookup that hits the entry under the pointer moves the pointer on by one. Any other lookup leaves it where it is. As a result the pointer tends to rest on an entry that has not been touched lately. Until the store has filled, a refill takes the lowest-numbered empty entry. After that it takes the entry under the pointer.

The data array and the memory side sit outside this block. A refill strobe with the missing address is the only link to them. The surrounding controller reads `victim_idx` to learn where the new block's data must go.

Top module: `ptrrep_tag_store`

## Requirements
- R1: After synchronous reset every entry is invalid and the pointer names entry 0, so `victim_idx` reads 0 and every lookup misses.
- R2: The tag of an address is bits [31:5]. Bits [4:0] have no effect on whether a lookup hits or which entry it reports.
- R3: In the same cycle as `lookup_vld`, `hit` is 1 when a valid entry holds the lookup tag, and `hit_idx` gives that entry's number.
- R4: `hit` is 0 when no valid entry holds the tag, including an invalid entry whose stored tag matches. `hit_idx` is 0 whenever `hit` is 0.
- R5: A lookup that hits the entry the pointer names moves the pointer to the next entry, wrapping from 63 to 0. A lookup that misses, or hits another entry, leaves the pointer unchanged.
- R6: `victim_idx` is the lowest-numbered invalid entry while any entry is invalid, and the pointer once all entries are valid.
- R7: A refill writes the tag of `refill_addr` into the entry given by `victim_idx` in that cycle and marks it valid. The pointer becomes that entry plus one, modulo 64. From the next cycle on, the tag hits in that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_vld | input | 1 | Lookup request strobe |
| lookup_addr | input | 32 | Byte address of the lookup |
| refill_vld | input | 1 | Refill strobe, installs a block at the victim entry |
| refill_addr | input | 32 | Byte address of the block being installed |
| hit | output | 1 | Lookup found a valid matching entry (same cycle) |
| hit_idx | output | 6 | Number of the matching entry, 0 on a miss |
| victim_idx | output | 6 | Entry the next refill will use |

## Verification
`hit` and `hit_idx` are combinational from the lookup inputs and the stored state. They are due in the cycle the request is driven, and the bench samples them one nanosecond after it drives inputs on the falling edge. Pointer movement and refill writes take effect at the next rising edge. They therefore show on `victim_idx` and on later lookups only from the following falling edge. The bench updates its own model of tags, valid bits and the pointer just after each rising edge, so every expectation is formed from the state the design holds in that cycle.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
    localparam int ADDR_W      = 32;
    localparam int ENTRIES     = 64;
    localparam int BLOCK_BYTES = 32;
    localparam int OFS_W       = $clog2(BLOCK_BYTES);
    localparam int TAG_W       = ADDR_W - OFS_W;
    localparam int IDX_W       = $clog2(ENTRIES);

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [ENTRIES-1:0] vmask_t;

    typedef struct packed {
        logic hit;
        idx_t idx;
    } match_t;

    typedef struct packed {
        logic found;
        idx_t idx;
    } free_t;

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic idx_t next_idx(idx_t i);
        return (i == idx_t'(ENTRIES - 1)) ? '0 : i + idx_t'(1);
    endfunction
endpackage

// File: rtl/fa_entry_store.sv
module fa_entry_store
    import fa_cache_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  idx_t                     wr_idx,
    input  tag_t                     wr_tag,
    output tag_t [ENTRIES-1:0]       tags_o,
    output vmask_t                   valid_o
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == idx_t'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_o[e] <= 1'b0;
            end else if (sel) begin
                valid_o[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tags_o[e] <= wr_tag;
            end
        end
    end
endmodule

// File: rtl/fa_tag_match.sv
module fa_tag_match
    import fa_cache_pkg::*;
(
    input  logic               req_vld,
    input  tag_t               req_tag,
    input  tag_t [ENTRIES-1:0] tags_i,
    input  vmask_t             valid_i,
    output match_t             match_o
);
    vmask_t eq;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign eq[e] = req_vld && valid_i[e] && (tags_i[e] == req_tag);
    end

    always_comb begin
        match_o = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (eq[e]) begin
                match_o.hit = 1'b1;
                match_o.idx = idx_t'(e);
            end
        end
    end
endmodule

// File: rtl/fa_free_scan.sv
module fa_free_scan
    import fa_cache_pkg::*;
(
    input  vmask_t valid_i,
    output free_t  free_o
);
    always_comb begin
        free_o = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!valid_i[e]) begin
                free_o.found = 1'b1;
                free_o.idx   = idx_t'(e);
            end
        end
    end
endmodule

// File: rtl/fa_repl_ptr.sv
module fa_repl_ptr
    import fa_cache_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  idx_t load_val,
    input  logic step,
    output idx_t ptr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o <= '0;
        end else if (load) begin
            ptr_o <= load_val;
        end else if (step) begin
            ptr_o <= next_idx(ptr_o);
        end
    end
endmodule

// File: rtl/ptrrep_tag_store.sv
module ptrrep_tag_store
    import fa_cache_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lookup_vld,
    input  logic [31:0] lookup_addr,
    input  logic        refill_vld,
    input  logic [31:0] refill_addr,
    output logic        hit,
    output logic [5:0]  hit_idx,
    output logic [5:0]  victim_idx
);
    tag_t [ENTRIES-1:0] tags_q;
    vmask_t             valid_q;
    idx_t               ptr_q;
    match_t             mres;
    free_t              fres;
    idx_t               victim;
    logic               ptr_step;

    fa_entry_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (refill_vld),
        .wr_idx  (victim),
        .wr_tag  (tag_of(refill_addr)),
        .tags_o  (tags_q),
        .valid_o (valid_q)
    );

    fa_tag_match u_match (
        .req_vld (lookup_vld),
        .req_tag (tag_of(lookup_addr)),
        .tags_i  (tags_q),
        .valid_i (valid_q),
        .match_o (mres)
    );

    fa_free_scan u_free (
        .valid_i (valid_q),
        .free_o  (fres)
    );

    // a refill owns the pointer in its cycle; otherwise a hit on the pointed entry steps it
    assign ptr_step = mres.hit && (mres.idx == ptr_q);
    assign victim   = fres.found ? fres.idx : ptr_q;

    fa_repl_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (refill_vld),
        .load_val (next_idx(victim)),
        .step     (ptr_step),
        .ptr_o    (ptr_q)
    );

    assign hit        = mres.hit;
    assign hit_idx    = mres.idx;
    assign victim_idx = victim;
endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk
    import fa_cache_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   lookup_vld,
    input logic   refill_vld,
    input logic   hit,
    input idx_t   hit_idx,
    input idx_t   victim_idx,
    input idx_t   ptr,
    input vmask_t valid
);
    // R1: state right after reset is cleared
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ptr == '0 && valid == '0));

    // R3: a reported hit names a valid entry
    p_hit_valid_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> (lookup_vld && valid[hit_idx]));

    // R4: no hit means index reads zero
    p_miss_idx_r4: assert property (@(posedge clk) disable iff (rst)
        !hit |-> hit_idx == '0);

    // R5: pointer steps by one (wrapping) on a hit at the pointer
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!refill_vld && hit && hit_idx == ptr) |=> ptr == $past(ptr) + idx_t'(1));

    // R5: pointer holds otherwise
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!refill_vld && !(hit && hit_idx == ptr)) |=> $stable(ptr));

    // R6: while any entry is free the victim is free
    p_victim_free_r6: assert property (@(posedge clk) disable iff (rst)
        (valid != '1) |-> !valid[victim_idx]);

    // R6: a full store victimises the pointer
    p_victim_ptr_r6: assert property (@(posedge clk) disable iff (rst)
        (valid == '1) |-> victim_idx == ptr);

    // R7: refilled entry becomes valid and pointer moves past it
    p_refill_r7: assert property (@(posedge clk) disable iff (rst)
        refill_vld |=> (valid[$past(victim_idx)] && ptr == $past(victim_idx) + idx_t'(1)));
endmodule

bind ptrrep_tag_store fa_cache_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .lookup_vld (lookup_vld),
    .refill_vld (refill_vld),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .victim_idx (victim_idx),
    .ptr        (ptr_q),
    .valid      (valid_q)
);

// File: tb/ptrrep_tag_store_tb_top.sv
module ptrrep_tag_store_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lookup_vld = 1'b0;
    logic [31:0] lookup_addr = '0;
    logic        refill_vld = 1'b0;
    logic [31:0] refill_addr = '0;
    logic        hit;
    logic [5:0]  hit_idx;
    logic [5:0]  victim_idx;

    int n_chk = 0;
    int n_bad = 0;

    logic [26:0] mtag [64];
    logic        mval [64];
    int          mptr;

    always #2.5 clk = ~clk;

    ptrrep_tag_store dut_i (
        .clk(clk), .rst(rst),
        .lookup_vld(lookup_vld), .lookup_addr(lookup_addr),
        .refill_vld(refill_vld), .refill_addr(refill_addr),
        .hit(hit), .hit_idx(hit_idx), .victim_idx(victim_idx)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int exp_victim();
        for (int i = 0; i < 64; i++) if (!mval[i]) return i;
        return mptr;
    endfunction

    function automatic logic [26:0] fill_tag(input int i);
        return 27'h0A000 + 27'(i * 13);
    endfunction

    // one cycle: drive at falling edge, check combinational results, advance model at rising edge
    task automatic step(input logic lv, input logic [31:0] la,
                        input logic rv, input logic [31:0] ra, input string rq);
        int eh, ei, ev;
        @(negedge clk);
        lookup_vld = lv; lookup_addr = la;
        refill_vld = rv; refill_addr = ra;
        #1;
        eh = 0; ei = 0;
        if (lv) begin
            for (int i = 0; i < 64; i++)
                if (eh == 0 && mval[i] && mtag[i] == la[31:5]) begin eh = 1; ei = i; end
        end
        ev = exp_victim();
        chk(rq, "hit", int'(hit), eh);
        chk(rq, "hit_idx", int'(hit_idx), ei);
        chk(rq, "victim_idx", int'(victim_idx), ev);
        @(posedge clk);
        if (rv) begin
            mtag[ev] = ra[31:5];
            mval[ev] = 1'b1;
            mptr = (ev + 1) % 64;
        end else if (eh == 1 && ei == mptr) begin
            mptr = (mptr + 1) % 64;
        end
    endtask

    task automatic idle(input string rq);
        step(1'b0, '0, 1'b0, '0, rq);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; lookup_vld = 1'b0; refill_vld = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 64; i++) mval[i] = 1'b0;
        mptr = 0;
        @(negedge clk);
        rst = 1'b0;
        // R1: every lookup misses and the victim is entry 0
        step(1'b1, {fill_tag(0), 5'h00}, 1'b0, '0, "R1");
        step(1'b1, {fill_tag(5), 5'h00}, 1'b0, '0, "R1");
        chk("R1", "victim_idx after reset", int'(victim_idx), 0);
    endtask

    task automatic t_fill_partial();
        // R6 R7: empty entries are taken lowest first
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, {fill_tag(i), 5'h00}, "R7");
        idle("R6");
        chk("R6", "victim after three fills", int'(victim_idx), 3);
        step(1'b1, {fill_tag(2), 5'h00}, 1'b0, '0, "R3");
    endtask

    task automatic t_fill_all();
        for (int i = 3; i < 64; i++) step(1'b0, '0, 1'b1, {fill_tag(i), 5'h00}, "R7");
        idle("R6");
        chk("R6", "victim once full", int'(victim_idx), 0);
    endtask

    task automatic t_lookup_hits();
        // R3: hits on various entries away from the pointer
        step(1'b1, {fill_tag(5), 5'h00}, 1'b0, '0, "R3");
        step(1'b1, {fill_tag(63), 5'h00}, 1'b0, '0, "R3");
        step(1'b1, {fill_tag(31), 5'h00}, 1'b0, '0, "R3");
        // R2: offset bits do not matter
        step(1'b1, {fill_tag(17), 5'h1F}, 1'b0, '0, "R2");
        step(1'b1, {fill_tag(40), 5'h0B}, 1'b0, '0, "R2");
        // R5: hits elsewhere leave the pointer at 0
        idle("R5");
        chk("R5", "pointer after non-pointer hits", int'(victim_idx), 0);
    endtask

    task automatic t_miss();
        // R4: absent tags, and lookup strobe low
        step(1'b1, {27'h7FF_FFFF, 5'h00}, 1'b0, '0, "R4");
        step(1'b1, {27'h0000001, 5'h04}, 1'b0, '0, "R4");
        step(1'b0, {fill_tag(0), 5'h00}, 1'b0, '0, "R4");
        idle("R5");
        chk("R5", "pointer after misses", int'(victim_idx), 0);
    endtask

    task automatic t_ptr_walk();
        // R5: hit the pointed entry repeatedly, including the 63 -> 0 wrap
        for (int k = 0; k < 70; k++) step(1'b1, {mtag[mptr], 5'h07}, 1'b0, '0, "R5");
        idle("R5");
        chk("R5", "pointer after 70 steps with wrap", int'(victim_idx), 6);
    endtask

    task automatic t_full_refill();
        logic [26:0] old_t;
        old_t = mtag[mptr];
        // R7: replace at pointer when full
        step(1'b0, '0, 1'b1, {27'h5550001, 5'h00}, "R7");
        step(1'b1, {27'h5550001, 5'h10}, 1'b0, '0, "R7");
        chk("R7", "new tag lands at old pointer", int'(hit_idx), 6);
        step(1'b1, {old_t, 5'h00}, 1'b0, '0, "R7");
        step(1'b0, '0, 1'b1, {27'h5550002, 5'h00}, "R7");
        step(1'b0, '0, 1'b1, {27'h5550003, 5'h00}, "R7");
        idle("R7");
        chk("R7", "pointer after three refills", int'(victim_idx), 9);
    endtask

    task automatic t_reset_midrun();
        // R1 R4: stored tags remain but invalid entries never hit
        t_reset();
        step(1'b1, {fill_tag(10), 5'h00}, 1'b0, '0, "R4");
        step(1'b1, {27'h5550001, 5'h00}, 1'b0, '0, "R4");
    endtask

    logic done = 1'b0;

    initial begin
        for (int i = 0; i < 64; i++) begin mtag[i] = '0; mval[i] = 1'b0; end
        mptr = 0;
        t_reset();
        t_fill_partial();
        t_fill_all();
        t_lookup_hits();
        t_miss();
        t_ptr_walk();
        t_full_refill();
        t_reset_midrun();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule